// File: doc/BRIEF.md
# Serial Controller Interrupt Status and Mask Unit

This block collects the interrupt conditions of a two-channel serial controller into one 8-bit status word. The conditions are the transmit-ready, receive-ready and break-change events of each channel, a counter-ready level, and state changes on four general-purpose input pins. A programmable mask selects which conditions drive a single active-low interrupt request. A CPU reaches the status, mask, masked-status, vector, pin-enable and port-change registers over a simple strobe-based register bus. Reads are combinational, and writes take effect at the next clock edge.

The four input pins pass through a two-flop synchronizer. A change on a pin is recorded only when that pin's enable bit is set. The port-change side is controlled by a two-state machine. `IPC_QUIET` means that no enabled change is pending. An enabled change moves it to `IPC_PENDING`. A read of the port-change register with no new change in that cycle returns it to `IPC_QUIET`. A read that coincides with a new change keeps it in `IPC_PENDING`. No other access leaves `IPC_PENDING`.

Top module: `duart_irq_unit`

## Requirements
- R1: After reset the mask register is 0x00, the vector register reads 0x0F, all pin enables and pin change flags are 0, and `irq_n` is 1.
- R2: Status bits follow their source levels one clock edge after the source changes: bit 0 follows `tx_rdy_a`, bit 1 follows `rx_rdy_a`, bit 3 follows `ctr_rdy`, bit 4 follows `tx_rdy_b` and bit 5 follows `rx_rdy_b`. The status register is read at offset 0x5.
- R3: Status bit 2 (channel A) and bit 6 (channel B) are set by a one-cycle break event pulse. Each stays set until its clear strobe, and it is still set when an event and a clear arrive in the same cycle.
- R4: A write to offset 0x5 loads the mask register. A read at offset 0x2 returns the status bits ANDed with the mask.
- R5: `irq_n` is 0 exactly when at least one masked status bit is 1.
- R6: A write to offset 0x4 loads the pin enables from `bus_wdata[3:0]`, where bit n enables `gp_in[n]`. An enabled pin change sets status bit 7 no later than the third clock edge after the pin changes. A change on a disabled pin leaves bit 7 at 0.
- R7: A read at offset 0x4 returns the port-change register. Bits 7:4 hold the sticky change flags of pins 3..0, and bits 3:0 hold the synchronized pin levels. This read clears the flags and status bit 7 at the next edge.
- R8: Once set, status bit 7 stays set across status reads, masked-status reads and pin-enable writes.
- R9: Offset 0xC holds an 8-bit read/write vector register. Reads of unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| tx_rdy_a | input | 1 | Channel A transmit-ready level |
| rx_rdy_a | input | 1 | Channel A receive-ready or FIFO-full level |
| brk_evt_a | input | 1 | Channel A break start/end pulse |
| brk_clr_a | input | 1 | Clear strobe for the channel A break bit |
| tx_rdy_b | input | 1 | Channel B transmit-ready level |
| rx_rdy_b | input | 1 | Channel B receive-ready or FIFO-full level |
| brk_evt_b | input | 1 | Channel B break start/end pulse |
| brk_clr_b | input | 1 | Clear strobe for the channel B break bit |
| ctr_rdy | input | 1 | Counter/timer ready level |
| gp_in | input | 4 | General-purpose input pins |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Level-sourced status bits and break bits are registered once, so the bench drives them in a low clock phase and reads them after the following falling edge. `irq_n` and the masked status are combinational from the registers and are sampled in that same phase. A pin change passes two synchronizer flops and then the flag register, so the bench waits three falling edges before it reads. The clearing effect of a port-change read appears after the edge that samples the read strobe, so the bench checks it only on the next access.

// File: rtl/duart_irq_pkg.sv
package duart_irq_pkg;
    localparam int DW   = 8;
    localparam int NPIN = 4;

    localparam logic [3:0] OFF_MASKED = 4'h2;
    localparam logic [3:0] OFF_PORT   = 4'h4;
    localparam logic [3:0] OFF_STAT   = 4'h5;
    localparam logic [3:0] OFF_VEC    = 4'hC;

    localparam int B_TXA = 0;
    localparam int B_RXA = 1;
    localparam int B_BKA = 2;
    localparam int B_CTR = 3;
    localparam int B_TXB = 4;
    localparam int B_RXB = 5;
    localparam int B_BKB = 6;
    localparam int B_IPC = 7;

    typedef enum logic [0:0] {
        IPC_QUIET   = 1'b0,
        IPC_PENDING = 1'b1
    } ipc_state_t;
endpackage

// File: rtl/duart_ipc_detect.sv
module duart_ipc_detect
    import duart_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins,
    input  logic [NPIN-1:0] pin_en,
    input  logic            port_rd,
    output logic            pending,
    output logic [DW-1:0]   port_val
);
    logic [NPIN-1:0] sync_q [SYNC_STAGES];
    logic [NPIN-1:0] prev_q;
    logic [NPIN-1:0] flags_q;
    logic [NPIN-1:0] chg;
    ipc_state_t      state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= pins;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign chg = (sync_q[SYNC_STAGES-1] ^ prev_q) & pin_en;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IPC_QUIET:   if (|chg) state_d = IPC_PENDING;
            IPC_PENDING: if (port_rd && !(|chg)) state_d = IPC_QUIET;
            default:     state_d = IPC_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IPC_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flags_q <= '0;
        else if (port_rd) flags_q <= chg;
        else              flags_q <= flags_q | chg;
    end

    always_comb begin
        pending  = (state_q == IPC_PENDING);
        port_val = {flags_q, sync_q[SYNC_STAGES-1]};
    end

    assert_state_tracks_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IPC_PENDING) == (flags_q != '0));
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && chg == '0) |=> (state_q == IPC_QUIET && flags_q == '0));
    assert_pending_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IPC_PENDING && !port_rd) |=> (state_q == IPC_PENDING));
endmodule

// File: rtl/duart_irq_status.sv
module duart_irq_status
    import duart_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_a,
    input  logic          rx_a,
    input  logic          brk_a,
    input  logic          clr_a,
    input  logic          tx_b,
    input  logic          rx_b,
    input  logic          brk_b,
    input  logic          clr_b,
    input  logic          ctr,
    input  logic          ipc_pending,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] status,
    output logic          irq_n
);
    logic [B_IPC-1:0] stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q[B_TXA] <= tx_a;
            stat_q[B_RXA] <= rx_a;
            stat_q[B_BKA] <= brk_a | (stat_q[B_BKA] & ~clr_a);
            stat_q[B_CTR] <= ctr;
            stat_q[B_TXB] <= tx_b;
            stat_q[B_RXB] <= rx_b;
            stat_q[B_BKB] <= brk_b | (stat_q[B_BKB] & ~clr_b);
        end
    end

    always_comb begin
        status = {ipc_pending, stat_q};
        irq_n  = ~|(status & mask);
    end

    assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[B_TXA] == $past(tx_a) && status[B_RXB] == $past(rx_b)));
    assert_brk_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_BKA] && !clr_a) |=> status[B_BKA]);
    assert_brk_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        brk_b |=> status[B_BKB]);
endmodule

// File: rtl/duart_irq_bus.sv
module duart_irq_bus
    import duart_irq_pkg::*;
#(
    parameter int            AW        = 4,
    parameter logic [DW-1:0] VEC_RESET = 8'h0F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic            rd,
    input  logic            wr,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   status,
    input  logic [DW-1:0]   port_val,
    output logic [DW-1:0]   rdata,
    output logic [DW-1:0]   mask,
    output logic [NPIN-1:0] pin_en,
    output logic            port_rd
);
    logic [DW-1:0] vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask   <= '0;
            pin_en <= '0;
            vec_q  <= VEC_RESET;
        end else if (wr) begin
            unique case (addr)
                AW'(OFF_STAT): mask   <= wdata;
                AW'(OFF_PORT): pin_en <= wdata[NPIN-1:0];
                AW'(OFF_VEC):  vec_q  <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            AW'(OFF_STAT):   rdata = status;
            AW'(OFF_MASKED): rdata = status & mask;
            AW'(OFF_PORT):   rdata = port_val;
            AW'(OFF_VEC):    rdata = vec_q;
            default:         rdata = '0;
        endcase
        port_rd = rd && (addr == AW'(OFF_PORT));
    end

    assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == AW'(OFF_STAT)) |=> (mask == $past(wdata)));
    assert_vec_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == AW'(OFF_VEC)) |=> (rd && addr == AW'(OFF_VEC)) |-> (rdata == $past(wdata)));
endmodule

// File: rtl/duart_irq_unit.sv
module duart_irq_unit
    import duart_irq_pkg::*;
#(
    parameter int            AW          = 4,
    parameter int            SYNC_STAGES = 2,
    parameter logic [DW-1:0] VEC_RESET   = 8'h0F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            tx_rdy_a,
    input  logic            rx_rdy_a,
    input  logic            brk_evt_a,
    input  logic            brk_clr_a,
    input  logic            tx_rdy_b,
    input  logic            rx_rdy_b,
    input  logic            brk_evt_b,
    input  logic            brk_clr_b,
    input  logic            ctr_rdy,
    input  logic [NPIN-1:0] gp_in,
    output logic            irq_n
);
    logic [DW-1:0]   status, mask, port_val;
    logic [NPIN-1:0] pin_en;
    logic            port_rd, ipc_pending;

    duart_ipc_detect #(.SYNC_STAGES(SYNC_STAGES)) u_ipc (
        .clk(clk), .rst_n(rst_n), .pins(gp_in), .pin_en(pin_en),
        .port_rd(port_rd), .pending(ipc_pending), .port_val(port_val)
    );

    duart_irq_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .tx_a(tx_rdy_a), .rx_a(rx_rdy_a), .brk_a(brk_evt_a), .clr_a(brk_clr_a),
        .tx_b(tx_rdy_b), .rx_b(rx_rdy_b), .brk_b(brk_evt_b), .clr_b(brk_clr_b),
        .ctr(ctr_rdy), .ipc_pending(ipc_pending), .mask(mask),
        .status(status), .irq_n(irq_n)
    );

    duart_irq_bus #(.AW(AW), .VEC_RESET(VEC_RESET)) u_bus (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .wdata(bus_wdata), .status(status), .port_val(port_val),
        .rdata(bus_rdata), .mask(mask), .pin_en(pin_en), .port_rd(port_rd)
    );

    assert_irq_matches_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == AW'(OFF_MASKED)) |-> ((bus_rdata != '0) == !irq_n));
    assert_irq_released_in_reset_R1: assert property (@(posedge clk)
        !rst_n |=> irq_n);
endmodule

// File: tb/duart_irq_unit_test.sv
module duart_irq_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_rdy_a = 0, rx_rdy_a = 0, brk_evt_a = 0, brk_clr_a = 0;
    logic       tx_rdy_b = 0, rx_rdy_b = 0, brk_evt_b = 0, brk_clr_b = 0;
    logic       ctr_rdy = 0;
    logic [3:0] gp_in = '0;
    logic       irq_n;

    int applied = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    duart_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_rdy_a(tx_rdy_a), .rx_rdy_a(rx_rdy_a), .brk_evt_a(brk_evt_a),
        .brk_clr_a(brk_clr_a), .tx_rdy_b(tx_rdy_b), .rx_rdy_b(rx_rdy_b),
        .brk_evt_b(brk_evt_b), .brk_clr_b(brk_clr_b), .ctr_rdy(ctr_rdy),
        .gp_in(gp_in), .irq_n(irq_n)
    );

    // {source levels, mask, expected status, expected irq_n}
    localparam logic [31:0] VECS [6] = '{
        {8'h01, 8'h01, 8'h01, 8'h00},
        {8'h3B, 8'h00, 8'h3B, 8'h01},
        {8'h3B, 8'h04, 8'h3B, 8'h01},
        {8'h10, 8'h10, 8'h10, 8'h00},
        {8'h22, 8'h08, 8'h22, 8'h01},
        {8'h08, 8'hFF, 8'h08, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] d;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        check("R1 irq_n", {7'b0, irq_n}, 8'h01);
        rd(4'hC, d); check("R1 vector", d, 8'h0F);
        rd(4'h2, d); check("R1 masked", d, 8'h00);
        rd(4'h4, d); check("R1 port", d, 8'h00);

        // R2 R4 R5: level sources under several masks
        foreach (VECS[i]) begin
            logic [7:0] src, msk, est;
            src = VECS[i][31:24]; msk = VECS[i][23:16]; est = VECS[i][15:8];
            tx_rdy_a = src[0]; rx_rdy_a = src[1]; ctr_rdy = src[3];
            tx_rdy_b = src[4]; rx_rdy_b = src[5];
            wr(4'h5, msk);
            rd(4'h5, d); check("R2 status", d, est);
            rd(4'h2, d); check("R4 masked", d, est & msk);
            check("R5 irq_n", {7'b0, irq_n}, VECS[i][7:0]);
        end
        tx_rdy_a = 0; rx_rdy_a = 0; ctr_rdy = 0; tx_rdy_b = 0; rx_rdy_b = 0;
        wr(4'h5, 8'h00);

        // R3: sticky break bits
        brk_evt_a = 1; step(1); brk_evt_a = 0;
        rd(4'h5, d); check("R3 brk A set", d, 8'h04);
        step(3);
        rd(4'h5, d); check("R3 brk A held", d, 8'h04);
        brk_clr_a = 1; step(1); brk_clr_a = 0;
        rd(4'h5, d); check("R3 brk A cleared", d, 8'h00);
        brk_evt_a = 1; brk_clr_a = 1; step(1); brk_evt_a = 0; brk_clr_a = 0;
        rd(4'h5, d); check("R3 set wins", d, 8'h04);
        brk_clr_a = 1; step(1); brk_clr_a = 0;
        brk_evt_b = 1; step(1); brk_evt_b = 0;
        rd(4'h5, d); check("R3 brk B set", d, 8'h40);
        brk_clr_b = 1; step(1); brk_clr_b = 0;
        rd(4'h5, d); check("R3 brk B cleared", d, 8'h00);

        // R6: pin enables
        wr(4'h4, 8'hF1);
        gp_in[1] = 1'b1; step(3);
        rd(4'h5, d); check("R6 disabled pin", d, 8'h00);
        gp_in[0] = 1'b1; step(3);
        rd(4'h5, d); check("R6 enabled pin", d, 8'h80);
        wr(4'h5, 8'h80);
        check("R5 irq on port change", {7'b0, irq_n}, 8'h00);

        // R8: no other access clears bit 7
        rd(4'h5, d); rd(4'h2, d); check("R8 masked read", d, 8'h80);
        wr(4'h4, 8'h00);
        rd(4'h5, d); check("R8 after enable write", d, 8'h80);

        // R7: port-change read and clear
        rd(4'h4, d); check("R7 port value", d, 8'h13);
        rd(4'h5, d); check("R7 bit7 cleared", d, 8'h00);
        rd(4'h4, d); check("R7 flags cleared", d, 8'h03);
        check("R7 irq released", {7'b0, irq_n}, 8'h01);

        // R9: vector register and unmapped offset
        wr(4'hC, 8'hA5);
        rd(4'hC, d); check("R9 vector", d, 8'hA5);
        rd(4'h7, d); check("R9 unmapped", d, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule